// File: doc/BRIEF.md
# Triple-Lane Conversion Frame Sequencer

This block is the digital sequencing and shift logic for a three-lane, simultaneously sampled converter. It runs on the external conversion clock and starts a conversion when the active-low request `conv_n` is seen low at a rising edge while the sequencer is idle. A frame lasts 14 clock positions, and the start edge is position 1. During the frame, three 12-bit two's-complement results are shifted out MSB first on three bit-aligned serial lines. In the same frame, a 13-bit setup word for the next conversion is shifted in on `setup_in`.

The setup word is double buffered. Its DAC field reaches `dac_code` at the frame's final edge. Its gain and select fields are parked in a staging register at that edge and become active at the start edge of the following conversion. The first conversion after reset therefore runs with a placeholder configuration, and the second conversion loads the intended one. `data_valid` rises only once two frames have completed. The converter core is outside this block: its three results arrive on `res_a`, `res_b` and `res_c` and are captured at the start edge.

The controller has three states:
- IDLE waits for a request. IDLE to SAMPLE happens on a start.
- SAMPLE is the single position-1 cycle, during which the sample strobe is high. SAMPLE to SHIFT is unconditional.
- SHIFT runs positions 2 to 14. SHIFT to IDLE happens on the position-14 edge, which is the frame end.

Top module: `conv_frame_seq`

## Requirements
- R1: In IDLE, the first rising edge at which `conv_n` is low starts a conversion. After that edge, `busy_n` is 0 and `sample_stb` is 1 for exactly one cycle. While `conv_n` stays high, `busy_n` stays 1.
- R2: Each serial output drives one result bit per edge, MSB first. After the j-th edge following the start edge (j = 1..12), each line carries bit 12-j of its lane's result. At all other times each line is 0. All three lanes are bit-aligned.
- R3: Results are 12-bit two's complement (0x7FF is +full scale minus 1 LSB, 0x000 is mid-scale, 0x800 is -full scale). They are captured at the start edge, and later changes on the result inputs do not alter the frame's output.
- R4: `setup_in` is sampled at frame positions 2 to 14. The 13 sampled bits form a word whose first 8 bits are the DAC code (MSB first), next 2 bits are the gain code (MSB first), and last 3 bits are the select code (MSB first).
- R5: `dac_code` takes the new DAC field at the position-14 edge and holds its value at every other edge.
- R6: The gain and select fields from frame N are output on `gain_code` and `sel_code` from the start edge of frame N+1 onward. During frame N, the values loaded at frame N's own start remain in place.
- R7: `busy_n` is 0 from the start edge until the position-14 edge, which is one clock after the last result bit is driven. After that edge it is 1.
- R8: A request seen while `busy_n` is 0 does not alter the frame timing. It sets the sticky `overrun` flag, which only reset clears.
- R9: `data_valid` is 0 until two frames have completed after reset. It goes to 1 at the position-14 edge of the second frame and then stays 1.
- R10: Reset, including reset in mid-frame, returns the sequencer to IDLE. After reset, `busy_n`=1, all serial outputs are 0, all codes are 0, and `data_valid`, `overrun` and `sample_stb` are 0.
- R11: If `conv_n` is low at the first edge after a frame end, a new conversion starts at that edge with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_n | input | 1 | Active-low conversion request |
| setup_in | input | 1 | Serial setup word for the next conversion |
| res_a | input | 12 | Lane A result from the converter core |
| res_b | input | 12 | Lane B result from the converter core |
| res_c | input | 12 | Lane C result from the converter core |
| sout_a | output | 1 | Lane A serial result |
| sout_b | output | 1 | Lane B serial result |
| sout_c | output | 1 | Lane C serial result |
| busy_n | output | 1 | Active-low conversion in progress |
| sample_stb | output | 1 | One-cycle sample strobe at conversion start |
| dac_code | output | 8 | Committed DAC code |
| gain_code | output | 2 | Active gain code |
| sel_code | output | 3 | Active input-select code |
| data_valid | output | 1 | High once two frames have completed |
| overrun | output | 1 | Sticky flag for requests ignored while busy |

## Verification
The bench builds the block with its default widths: 12-bit results and an 8/2/3 split of the setup word. With these widths the frame is 14 positions long, so the last result bit and the final setup bit land on adjacent edges. Busy release, DAC commit and a back-to-back restart therefore all meet at the frame boundary and are checked in one run. The result vectors cover both full-scale extremes, mid-scale and alternating bit patterns, and the setup words exercise every field position.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_SHIFT  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/cfs_ctrl.sv
module cfs_ctrl
    import cfs_pkg::*;
#(
    parameter int RES_W     = 12,
    parameter int FRAME_LEN = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_n,
    output logic start,
    output logic shift_en,
    output logic cap_en,
    output logic frame_end,
    output logic busy_n,
    output logic sample_stb,
    output logic overrun,
    output logic data_valid
);
    localparam int PW = $clog2(FRAME_LEN + 1);

    seq_state_t    state_q, state_d;
    logic [PW-1:0] pos_q;
    logic [1:0]    done_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (!conv_n) state_d = ST_SAMPLE;
            ST_SAMPLE: state_d = ST_SHIFT;
            ST_SHIFT:  if (pos_q == PW'(FRAME_LEN - 1)) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and frame position (position of the last edge taken)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_IDLE)      pos_q <= '0;
            else if (state_q == ST_IDLE) pos_q <= PW'(1);
            else                         pos_q <= pos_q + PW'(1);
        end
    end

    // outputs decoded from state
    always_comb begin
        busy_n     = (state_q == ST_IDLE);
        sample_stb = (state_q == ST_SAMPLE);
        start      = (state_q == ST_IDLE) && !conv_n;
        cap_en     = (state_q != ST_IDLE);
        shift_en   = (state_q != ST_IDLE) && (pos_q <= PW'(RES_W));
        frame_end  = (state_q == ST_SHIFT) && (pos_q == PW'(FRAME_LEN - 1));
    end

    // sticky overrun and completed-frame count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overrun <= 1'b0;
            done_q  <= 2'd0;
        end else begin
            if (state_q != ST_IDLE && !conv_n) overrun <= 1'b1;
            if (frame_end && done_q != 2'd2)   done_q  <= done_q + 2'd1;
        end
    end

    assign data_valid = (done_q == 2'd2);

    assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_n && !conv_n) |=> (!busy_n && sample_stb));
    assert_strobe_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb);
    assert_busy_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_n) |-> ($past(pos_q) == PW'(FRAME_LEN - 1)));
    assert_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_n && !conv_n) |=> overrun);
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    assert_valid_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> data_valid);
endmodule

// File: rtl/cfs_lane.sv
module cfs_lane #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift_en,
    input  logic [RES_W-1:0] res,
    output logic             sout
);
    logic [RES_W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
            sout <= 1'b0;
        end else begin
            if (load)          sh_q <= res;
            else if (shift_en) sh_q <= {sh_q[RES_W-2:0], 1'b0};
            sout <= shift_en ? sh_q[RES_W-1] : 1'b0;
        end
    end

    assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> !sout);
endmodule

// File: rtl/cfs_setup.sv
module cfs_setup #(
    parameter int DAC_W  = 8,
    parameter int GAIN_W = 2,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              frame_end,
    input  logic              start,
    input  logic              ser_in,
    output logic [DAC_W-1:0]  dac_code,
    output logic [GAIN_W-1:0] gain_code,
    output logic [SEL_W-1:0]  sel_code
);
    localparam int SW = DAC_W + GAIN_W + SEL_W;

    logic [SW-2:0]     shadow_q;
    logic [SW-1:0]     word;
    logic [GAIN_W-1:0] stage_gain_q;
    logic [SEL_W-1:0]  stage_sel_q;

    assign word = {shadow_q, ser_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q     <= '0;
            dac_code     <= '0;
            stage_gain_q <= '0;
            stage_sel_q  <= '0;
            gain_code    <= '0;
            sel_code     <= '0;
        end else begin
            if (cap_en) shadow_q <= word[SW-2:0];
            if (frame_end) begin
                dac_code     <= word[SW-1 -: DAC_W];
                stage_gain_q <= word[GAIN_W+SEL_W-1 -: GAIN_W];
                stage_sel_q  <= word[SEL_W-1:0];
            end
            if (start) begin
                gain_code <= stage_gain_q;
                sel_code  <= stage_sel_q;
            end
        end
    end

    assert_dac_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(dac_code));
    assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(gain_code) && $stable(sel_code)));
endmodule

// File: rtl/conv_frame_seq.sv
module conv_frame_seq #(
    parameter int RES_W  = 12,
    parameter int DAC_W  = 8,
    parameter int GAIN_W = 2,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_n,
    input  logic              setup_in,
    input  logic [RES_W-1:0]  res_a,
    input  logic [RES_W-1:0]  res_b,
    input  logic [RES_W-1:0]  res_c,
    output logic              sout_a,
    output logic              sout_b,
    output logic              sout_c,
    output logic              busy_n,
    output logic              sample_stb,
    output logic [DAC_W-1:0]  dac_code,
    output logic [GAIN_W-1:0] gain_code,
    output logic [SEL_W-1:0]  sel_code,
    output logic              data_valid,
    output logic              overrun
);
    localparam int N_LANE    = 3;
    localparam int SETUP_W   = DAC_W + GAIN_W + SEL_W;
    localparam int FRAME_LEN = SETUP_W + 1;

    logic start, shift_en, cap_en, frame_end;
    logic [N_LANE-1:0][RES_W-1:0] res_bus;
    logic [N_LANE-1:0]            sout_bus;

    assign res_bus = {res_c, res_b, res_a};
    assign sout_a  = sout_bus[0];
    assign sout_b  = sout_bus[1];
    assign sout_c  = sout_bus[2];

    cfs_ctrl #(.RES_W(RES_W), .FRAME_LEN(FRAME_LEN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .conv_n(conv_n),
        .start(start), .shift_en(shift_en), .cap_en(cap_en),
        .frame_end(frame_end), .busy_n(busy_n), .sample_stb(sample_stb),
        .overrun(overrun), .data_valid(data_valid)
    );

    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
        cfs_lane #(.RES_W(RES_W)) u_lane (
            .clk(clk), .rst_n(rst_n), .load(start), .shift_en(shift_en),
            .res(res_bus[g]), .sout(sout_bus[g])
        );
    end

    cfs_setup #(.DAC_W(DAC_W), .GAIN_W(GAIN_W), .SEL_W(SEL_W)) u_setup (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .frame_end(frame_end),
        .start(start), .ser_in(setup_in), .dac_code(dac_code),
        .gain_code(gain_code), .sel_code(sel_code)
    );

    assert_lanes_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_n |=> (sout_bus == '0) || !busy_n);
endmodule

// File: tb/sim_conv_frame_seq.sv
module sim_conv_frame_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;
    // {res_a, res_b, res_c, setup word}
    localparam logic [48:0] VEC [NV] = '{
        {12'h7FF, 12'h800, 12'h000, 13'b10100101_11_010},
        {12'h001, 12'hFFF, 12'hA5A, 13'b01011010_00_101},
        {12'h800, 12'h7FF, 12'h5A5, 13'b11111111_01_111},
        {12'h000, 12'h123, 12'hFFF, 13'b00000001_10_001},
        {12'hC3C, 12'h000, 12'h800, 13'b10000000_11_100},
        {12'h3C3, 12'h001, 12'h7FF, 13'b00000000_00_000}
    };

    logic clk = 1'b0, rst_n = 1'b0, conv_n = 1'b1, setup_in = 1'b0;
    logic [11:0] res_a = '0, res_b = '0, res_c = '0;
    logic sout_a, sout_b, sout_c, busy_n, sample_stb, data_valid, overrun;
    logic [7:0] dac_code;
    logic [1:0] gain_code;
    logic [2:0] sel_code;

    int n_chk = 0, n_fail = 0, frames = 0;
    logic [7:0] exp_dac = '0;
    logic [1:0] exp_gain = '0, stg_gain = '0;
    logic [2:0] exp_sel = '0, stg_sel = '0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    conv_frame_seq u0 (
        .clk(clk), .rst_n(rst_n), .conv_n(conv_n), .setup_in(setup_in),
        .res_a(res_a), .res_b(res_b), .res_c(res_c),
        .sout_a(sout_a), .sout_b(sout_b), .sout_c(sout_c),
        .busy_n(busy_n), .sample_stb(sample_stb), .dac_code(dac_code),
        .gain_code(gain_code), .sel_code(sel_code),
        .data_valid(data_valid), .overrun(overrun)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    // One frame; caller is at a negedge. poke_pos>0 pulls conv_n low for that edge.
    task automatic run_frame(logic [11:0] a, logic [11:0] b, logic [11:0] c,
                             logic [12:0] word, int poke_pos);
        logic [11:0] ga, gb, gc;
        ga = '0; gb = '0; gc = '0;
        conv_n = 1'b0; res_a = a; res_b = b; res_c = c;
        @(posedge clk); @(negedge clk);
        exp_gain = stg_gain; exp_sel = stg_sel;
        chk("R1 busy after start", busy_n, 0);
        chk("R1 sample strobe", sample_stb, 1);
        chk("R6 gain applied at start", gain_code, exp_gain);
        chk("R6 select applied at start", sel_code, exp_sel);
        chk("R2 idle line at pos1", {sout_a, sout_b, sout_c}, 0);
        conv_n = 1'b1; res_a = ~a; res_b = ~b; res_c = ~c;   // R3 captured at start
        for (int p = 2; p <= 14; p++) begin
            setup_in = word[14-p];
            conv_n = (p == poke_pos) ? 1'b0 : 1'b1;
            chk("R5 dac held mid-frame", dac_code, exp_dac);
            @(posedge clk); @(negedge clk);
            if (p <= 13) begin
                ga[13-p] = sout_a; gb[13-p] = sout_b; gc[13-p] = sout_c;
            end
            if (p == 2)  chk("R1 strobe one cycle", sample_stb, 0);
            if (p == 13) chk("R7 busy through last bit", busy_n, 0);
        end
        conv_n = 1'b1;
        frames++;
        exp_dac = word[12:5]; stg_gain = word[4:3]; stg_sel = word[2:0];
        chk("R7 busy released at pos14", busy_n, 1);
        chk("R4 R5 dac committed", dac_code, exp_dac);
        chk("R6 gain not yet applied", gain_code, exp_gain);
        chk("R2 R3 lane a", ga, a);
        chk("R2 R3 lane b", gb, b);
        chk("R2 R3 lane c", gc, c);
        chk("R2 line quiet after frame", {sout_a, sout_b, sout_c}, 0);
        chk("R9 data valid", data_valid, (frames >= 2) ? 1 : 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 busy at reset", busy_n, 1);
        chk("R10 codes at reset", {dac_code, gain_code, sel_code}, 0);
        chk("R10 flags at reset", {data_valid, overrun, sample_stb}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 idle without request", busy_n, 1);

        // table walk: frames back to back (R11)
        for (int i = 0; i < NV; i++) begin
            run_frame(VEC[i][48:37], VEC[i][36:25], VEC[i][24:13], VEC[i][12:0], 0);
            if (i == 0) chk("R9 not valid after one frame", data_valid, 0);
        end
        chk("R8 no overrun yet", overrun, 0);
        chk("R11 back to back frames", frames, NV);

        // R8 request while busy
        run_frame(12'h456, 12'h789, 12'hABC, 13'b11001100_10_011, 6);
        chk("R8 overrun set", overrun, 1);
        conv_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 ignored request no frame", busy_n, 1);
        chk("R8 overrun sticky", overrun, 1);
        run_frame(12'h0F0, 12'hF0F, 12'h00F, 13'b00110011_01_110, 0);
        chk("R6 gain from previous word", gain_code, 2'b10);
        chk("R6 select from previous word", sel_code, 3'b011);

        // R10 mid-frame reset
        conv_n = 1'b0; res_a = 12'hFFF; res_b = 12'hFFF; res_c = 12'hFFF;
        @(posedge clk); @(negedge clk);
        conv_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 busy after mid-frame reset", busy_n, 1);
        chk("R10 lines after reset", {sout_a, sout_b, sout_c}, 0);
        chk("R10 flags after reset", {data_valid, overrun, sample_stb}, 0);
        chk("R10 codes after reset", {dac_code, gain_code, sel_code}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 stays idle after reset", busy_n, 1);
        finish_run();
    end
endmodule